// File: doc/BRIEF.md
# Delta-Modulation Output Stage

This block is the final stage of a one-bit delta-modulation sample channel. It keeps a 7-bit output level that a mixer reads at all times. Every time the rate timer issues an output tick, the block takes the lowest bit of the current sample byte and moves the level by one step. A 1 moves it up and a 0 moves it down. The level never steps past either end of its range. When all eight bits of a byte have been used, the block loads the next waiting byte and raises a one-cycle refill request. If no byte is waiting, the block falls silent until the next byte boundary.

Only the upper six bits of the level form a step counter. The lowest bit is a plain latch that only a direct write can set. Software can load the level directly at any time, and the load does not depend on whether a sample is playing. If a direct write lands on the same clock as a step, the new level is the stepped value ANDed bitwise with the write data.

Top module: `dpcm_out_unit`

## Requirements
- R1: After reset, level_o is 0 and refill_o is 0, and the unit is silent. Eight output ticks later, with no byte waiting, level_o is still 0.
- R2: A cycle with wr_en_i high and no active step sets level_o to wr_data_i on the next clock. This holds whether or not the unit is silent.
- R3: On a tick while the unit is not silent, a current sample bit of 1 raises level_o[6:1] by one and a bit of 0 lowers it by one. level_o is updated on the next clock.
- R4: A step never takes level_o[6:1] above 63 or below 0. When it would, level_o holds its value instead.
- R5: Stepping never changes level_o[0].
- R6: The sample byte is used least significant bit first. It shifts right by one place on each tick.
- R7: A byte boundary occurs on every eighth tick. If byte_valid_i is high at that tick, byte_i becomes the next sample, silence is cleared, and refill_o is high for exactly the one cycle after that tick.
- R8: If byte_valid_i is low at a byte boundary, the unit becomes silent. The next eight ticks then leave level_o unchanged.
- R9: If a direct write and an active step happen in the same cycle, level_o becomes the stepped value ANDed with wr_data_i. This applies even when the step is held at a limit.
- R10: In a cycle with neither tick_i nor wr_en_i, level_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Output-clock enable from the rate timer |
| byte_valid_i | input | 1 | A sample byte is waiting on byte_i |
| byte_i | input | 8 | Waiting sample byte |
| wr_en_i | input | 1 | Direct level write strobe |
| wr_data_i | input | 7 | Direct level write data |
| level_o | output | 7 | Output level to the mixer |
| refill_o | output | 1 | One-cycle pulse after a waiting byte is taken |

## Verification
Each result is due exactly one clock after the input that causes it. A tick or a write presented before edge k shows on level_o after edge k. A byte taken at the boundary tick of edge k shows as refill_o high for the cycle after edge k. The bench drives inputs on the falling edge and samples shortly after the next rising edge. It runs its own cycle-level reference model of the level, the sample bits, the tick count and the silence state. The bench compares both outputs in every cycle, while it sweeps all write values, saturation at both ends, a range of byte patterns, collisions and silent periods.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/dpcm_bit_shifter.sv
module dpcm_bit_shifter
  import dpcm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output step_e             step_o,
  output logic              refill_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  left_q;
  logic              silent_q;
  logic              last_bit;

  assign last_bit = (left_q == CNT_W'(1));

  always_comb begin
    if (tick_i && !silent_q) step_o = shift_q[0] ? STEP_UP : STEP_DOWN;
    else                     step_o = STEP_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      left_q   <= CNT_W'(BYTE_W);
      silent_q <= 1'b1;
      refill_o <= 1'b0;
    end else begin
      refill_o <= 1'b0;
      if (tick_i) begin
        if (last_bit) begin
          left_q <= CNT_W'(BYTE_W);
          if (byte_valid_i) begin
            shift_q  <= byte_i;
            silent_q <= 1'b0;
            refill_o <= 1'b1;
          end else begin
            shift_q  <= shift_q >> 1;
            silent_q <= 1'b1;
          end
        end else begin
          left_q  <= left_q - CNT_W'(1);
          shift_q <= shift_q >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/dpcm_level_reg.sv
module dpcm_level_reg
  import dpcm_pkg::*;
#(
  parameter int CTR_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  step_e          step_i,
  input  logic           wr_en_i,
  input  logic [CTR_W:0] wr_data_i,
  output logic [CTR_W:0] level_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [CTR_W-1:0] ctr_q, ctr_step;
  logic             lsb_q;
  logic [CTR_W:0]   stepped, level_d;

  always_comb begin
    ctr_step = ctr_q;
    unique case (step_i)
      STEP_UP:   if (ctr_q != CTR_MAX) ctr_step = ctr_q + 1'b1;
      STEP_DOWN: if (ctr_q != '0)      ctr_step = ctr_q - 1'b1;
      default:   ctr_step = ctr_q;
    endcase
    stepped = {ctr_step, lsb_q};
    if (!wr_en_i)                level_d = stepped;
    else if (step_i != STEP_NONE) level_d = stepped & wr_data_i; // same-cycle merge
    else                          level_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q <= '0;
      lsb_q <= 1'b0;
    end else begin
      ctr_q <= level_d[CTR_W:1];
      lsb_q <= level_d[0];
    end
  end

  assign level_o = {ctr_q, lsb_q};
endmodule

// File: rtl/dpcm_out_unit.sv
module dpcm_out_unit
  import dpcm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wr_en_i,
  input  logic [CTR_W:0]    wr_data_i,
  output logic [CTR_W:0]    level_o,
  output logic              refill_o
);
  step_e step;

  dpcm_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .step_o       (step),
    .refill_o     (refill_o)
  );

  dpcm_level_reg #(.CTR_W(CTR_W)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .level_o   (level_o)
  );
endmodule

// File: rtl/dpcm_out_unit_chk.sv
module dpcm_out_unit_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [LVL_W-1:0] wr_data_i,
  input logic [LVL_W-1:0] level_o,
  input logic             refill_o
);
  // R2
  write_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !tick_i) |=> (level_o == $past(wr_data_i)));

  // R5
  lsb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (level_o[0] == $past(level_o[0])));

  // R4
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((level_o[LVL_W-1:1] == $past(level_o[LVL_W-1:1])) ||
                  ({1'b0, level_o[LVL_W-1:1]} == {1'b0, $past(level_o[LVL_W-1:1])} + 1'b1) ||
                  ({1'b0, level_o[LVL_W-1:1]} + 1'b1 == {1'b0, $past(level_o[LVL_W-1:1])})));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(level_o));

  // R9
  merge_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((level_o & ~$past(wr_data_i)) == '0));

  // R7
  refill_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !refill_o);
endmodule

bind dpcm_out_unit dpcm_out_unit_chk #(.LVL_W(CTR_W + 1)) u_chk (.*);

// File: tb/tb_dpcm_out_unit.sv
module tb_dpcm_out_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       wr_en_i = 1'b0;
  logic [6:0] wr_data_i = '0;
  logic [6:0] level_o;
  logic       refill_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [6:0] m_level = '0;
  logic [7:0] m_shift = '0;
  int         m_left = 8;
  bit         m_silent = 1'b1;
  bit         m_refill = 1'b0;

  always #5 clk_i = ~clk_i;

  dpcm_out_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .level_o(level_o), .refill_o(refill_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit t, input bit bv, input logic [7:0] b,
                     input bit we, input logic [6:0] wd, input string tag);
    logic [6:0] nl;
    int ctr;
    bit stepping;
    @(negedge clk_i);
    tick_i = t; byte_valid_i = bv; byte_i = b; wr_en_i = we; wr_data_i = wd;
    stepping = t && !m_silent;
    nl = m_level;
    if (stepping) begin
      ctr = int'(m_level[6:1]);
      if (m_shift[0]) begin if (ctr < 63) ctr++; end
      else begin if (ctr > 0) ctr--; end
      nl = {ctr[5:0], m_level[0]};
    end
    if (we) nl = stepping ? (nl & wd) : wd;
    m_refill = 1'b0;
    if (t) begin
      if (m_left == 1) begin
        m_left = 8;
        if (bv) begin m_shift = b; m_silent = 1'b0; m_refill = 1'b1; end
        else begin m_shift = m_shift >> 1; m_silent = 1'b1; end
      end else begin
        m_left--;
        m_shift = m_shift >> 1;
      end
    end
    m_level = nl;
    @(posedge clk_i); #1;
    check(tag, int'(level_o), int'(m_level));
    check("R7 refill", int'(refill_o), int'(m_refill));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 reset level", int'(level_o), 0);
    check("R1 reset refill", int'(refill_o), 0);
    for (int i = 0; i < 8; i++) cyc(1, 0, 8'hFF, 0, 7'd0, "R1 silent after reset");

    // every write value, silent, with ticks running
    for (int v = 0; v < 128; v++) cyc(1, 0, 8'h00, 1, 7'(v), "R2 write while silent");
    for (int v = 0; v < 128; v += 9) begin
      cyc(0, 0, 8'h00, 1, 7'(v), "R2 write no tick");
      cyc(0, 0, 8'h00, 0, 7'd0, "R10 idle hold");
    end

    // saturation high then low
    cyc(0, 1, 8'hFF, 1, 7'd126, "R2 preset high");
    for (int i = 0; i < 24; i++) cyc(1, 1, 8'hFF, 0, 7'd0, "R4 saturate high");
    cyc(0, 1, 8'h00, 1, 7'd1, "R2 preset low");
    for (int i = 0; i < 24; i++) cyc(1, 1, 8'h00, 0, 7'd0, "R4/R5 saturate low");

    // byte patterns, LSB first, interleaved idle cycles
    for (int p = 0; p < 48; p++) begin
      logic [7:0] pat;
      pat = (p < 4) ? ((p == 0) ? 8'hAA : (p == 1) ? 8'h0F : (p == 2) ? 8'h55 : 8'hF0) : lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (p % 6 == 0) cyc(0, 1, pat, 1, 7'((p * 37) % 128), "R2 reposition");
      for (int i = 0; i < 8; i++) begin
        cyc(1, 1, pat, 0, 7'd0, "R3/R6 step");
        if (i % 3 == 0) cyc(0, 1, pat, 0, 7'd0, "R10 idle hold");
      end
    end

    // collisions with active steps, including at limits
    for (int v = 0; v < 128; v += 5) begin
      cyc(1, 1, lfsr, 1, 7'(v), "R9 write with step");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(1, 1, lfsr, 0, 7'd0, "R3 step");
    end
    cyc(0, 1, 8'hFF, 1, 7'd127, "R2 preset top");
    for (int i = 0; i < 10; i++) cyc(1, 1, 8'hFF, 0, 7'd0, "R4 hold top");
    cyc(1, 1, 8'hFF, 1, 7'h55, "R9 write with held step");

    // starve the unit
    for (int i = 0; i < 30; i++) cyc(1, 0, 8'h00, 0, 7'd0, "R8 silence");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule